// File: doc/BRIEF.md
# Byte-Addressed Word Memory Adapter

This block lets a requester that thinks in byte addresses use a memory that can only move whole 64-bit words and has no byte enables. The requester presents one request at a time: a byte address, a size, a write flag and write data. The adapter turns each request into one or two accesses on a word-indexed synchronous memory port. Only the word index reaches the memory. The three byte-select bits are used inside the adapter to pick, shift or merge lanes.

A byte read fetches the word that holds the byte and returns that byte in the low lane. A word read at an 8-byte boundary takes a single fetch. A word read at any other address takes two fetches: first the word holding the start byte, then the next word, wrapping at the top of the address space. The two results are spliced together. A byte write reads the word, replaces one lane, and writes all 64 bits back. A word write at an 8-byte boundary is written straight through. A word write at any other address is refused with an error pulse.

The memory port is assumed to return read data in the cycle after the read is issued. The adapter issues its first memory access in the same cycle as it accepts the request.

Top module: `byte_word_adapter`

## Requirements
- R1: Every memory access made for an accepted request carries `req_addr[ADDR_W-1:3]` as `mem_addr`. The three byte-select bits never reach the memory.
- R2: `req_size` = 0 selects a byte access and 1 selects an 8-byte access. A byte read returns the byte at the requested address in `rsp_data[7:0]`, with bits 63:8 cleared.
- R3: A byte read, or a word read whose address has low three bits 000, issues exactly one memory read. `rsp_valid` is high in the second cycle after the acceptance cycle.
- R4: A word read with nonzero low address bits issues two reads: word index w in the acceptance cycle, then w+1 (modulo the word count) in the next cycle. The result holds the eight consecutive bytes from the start address, lowest address in bits 7:0. `rsp_valid` is high in the third cycle after acceptance.
- R5: A byte write issues a read of the containing word, then in the next cycle a full-word write to the same index. Bits [8k+7:8k] of the written word hold `req_wdata[7:0]`, where k is the request's byte offset. Every other lane keeps its previous memory content.
- R6: A word write at an address whose low three bits are 000 issues one memory write of `req_wdata`, in the acceptance cycle, with no read.
- R7: A word write at an address whose low three bits are nonzero causes no memory access. `rsp_err` pulses high in the cycle after acceptance. The memory word at that index is unchanged afterwards.
- R8: `req_ready` is low in the cycle after any accepted read or byte write, and stays low until that operation's last memory access has been issued. `req_ready` stays high after an accepted word write.
- R9: While reset is held and right after it, `req_ready` is high and `mem_en`, `rsp_valid` and `rsp_err` are low. A reset in the middle of an operation abandons it with no response.
- R10: `rsp_valid` is a single-cycle pulse, given once for each accepted read and never for a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle and able to take a request |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 1 | 0 = one byte, 1 = eight bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data; bits 7:0 only for byte writes |
| rsp_valid | output | 1 | Read result present (one cycle) |
| rsp_data | output | 64 | Read result, right-justified |
| rsp_err | output | 1 | Pulse: unaligned word write refused |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | ADDR_W-3 | Word index |
| mem_wdata | output | 64 | Full word to write |
| mem_rdata | input | 64 | Word read, valid the cycle after the read |

## Verification
The assertions check the cycle structure on every cycle:
- the word index sent for each accepted request;
- the follow-on read at w+1 for a split read;
- the write-back in the cycle after a byte-write read;
- the pass-through of aligned word writes;
- the missing access and the error pulse for unaligned word writes;
- the busy window;
- the single-cycle response pulse.

Data content can only be shown by the bench's scenarios, because it depends on what the memory held. These scenarios cover lane selection and zero-fill, the splice of two words including wrap-around at the top word, preservation of the other lanes across a read-modify-write, and the unchanged memory word after a refused write. The bench also shows that a reset in mid-operation drops the pending response.

// File: rtl/byte_word_adapter.sv
`timescale 1ns/1ps
module byte_word_adapter #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_size,
  input  logic              req_write,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              rsp_err,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-4:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata
);
  localparam int WA_W = ADDR_W - 3;

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_LAST, S_RMW} state_t;
  state_t st;

  logic [WA_W-1:0] wa_q;
  logic [2:0]      off_q;
  logic            byte_q;
  logic [7:0]      wb_q;
  logic [63:0]     low_q;

  wire [2:0]      req_off = req_addr[2:0];
  wire [WA_W-1:0] req_wa  = req_addr[ADDR_W-1:3];
  wire            bad_wr  = req_write && req_size && (req_off != 3'd0);

  wire [5:0]  sh      = {off_q, 3'b000};
  wire [6:0]  sh_hi   = 7'd64 - {1'b0, sh};
  wire [63:0] shifted = mem_rdata >> sh;
  wire [63:0] lane_m  = 64'hFF << sh;
  wire [63:0] rmw_w   = (mem_rdata & ~lane_m) | ({56'd0, wb_q} << sh);

  assign req_ready = (st == S_IDLE);

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_IDLE: if (req_valid && !bad_wr) begin
        mem_en    = 1'b1;
        mem_we    = req_write && req_size;
        mem_addr  = req_wa;
        mem_wdata = req_wdata;
      end
      S_FIRST: begin
        mem_en   = 1'b1;
        mem_addr = wa_q + 1'b1;
      end
      S_RMW: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = wa_q;
        mem_wdata = rmw_w;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      wa_q      <= '0;
      off_q     <= '0;
      byte_q    <= 1'b0;
      wb_q      <= '0;
      low_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wa_q    <= req_wa;
          off_q   <= req_off;
          byte_q  <= !req_size;
          wb_q    <= req_wdata[7:0];
          rsp_err <= bad_wr;
          if (!req_write)
            st <= (req_size && req_off != 3'd0) ? S_FIRST : S_LAST;
          else if (!req_size)
            st <= S_RMW;
        end
        S_FIRST: begin
          low_q <= shifted;
          st    <= S_LAST;
        end
        S_LAST: begin
          rsp_valid <= 1'b1;
          if (byte_q)
            rsp_data <= {56'd0, shifted[7:0]};
          else if (off_q != 3'd0)
            rsp_data <= low_q | (mem_rdata << sh_hi);
          else
            rsp_data <= mem_rdata;
          st <= S_IDLE;
        end
        S_RMW: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/byte_word_adapter_chk.sv
`timescale 1ns/1ps
module byte_word_adapter_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_size,
  input logic              req_write,
  input logic [63:0]       req_wdata,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-4:0] mem_addr,
  input logic [63:0]       mem_wdata
);
  wire              acc = req_valid && req_ready;
  wire [2:0]        lo  = req_addr[2:0];
  wire [ADDR_W-4:0] wi  = req_addr[ADDR_W-1:3];
  wire              unal_wr = req_write && req_size && (lo != 3'd0);

  // R1
  addr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !unal_wr |-> mem_en && mem_addr == wi);
  // R3
  single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write && (!req_size || lo == 3'd0) |-> ##2 rsp_valid);
  // R4
  split_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write && req_size && lo != 3'd0 |=>
      mem_en && !mem_we && mem_addr == (ADDR_W-3)'($past(wi) + 1'b1));
  // R5
  rmw_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && !req_size |=> mem_en && mem_we && mem_addr == $past(wi));
  // R6
  word_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && req_size && lo == 3'd0 |-> mem_en && mem_we && mem_wdata == req_wdata);
  // R7
  refuse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && unal_wr |-> !mem_en);
  // R7
  refuse_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && unal_wr |=> rsp_err);
  // R8
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !(req_write && req_size) |=> !req_ready);
  // R10
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind byte_word_adapter byte_word_adapter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/byte_word_adapter_tb.sv
`timescale 1ns/1ps
module byte_word_adapter_tb;
  localparam int AW = 8;
  localparam int NW = 1 << (AW - 3);
  localparam int NV = 15;

  // {write, size, addr[7:0], wdata[63:0]}
  localparam logic [73:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 64'h0},
    {1'b0, 1'b0, 8'h0D, 64'h0},
    {1'b0, 1'b1, 8'h10, 64'h0},
    {1'b0, 1'b1, 8'h05, 64'h0},
    {1'b0, 1'b1, 8'hFF, 64'h0},
    {1'b1, 1'b0, 8'h13, 64'hFFFF_FFFF_FFFF_FF5A},
    {1'b0, 1'b1, 8'h10, 64'h0},
    {1'b1, 1'b1, 8'h20, 64'h0123_4567_89AB_CDEF},
    {1'b0, 1'b1, 8'h1D, 64'h0},
    {1'b1, 1'b1, 8'h44, 64'hDEAD_BEEF_DEAD_BEEF},
    {1'b0, 1'b1, 8'h40, 64'h0},
    {1'b0, 1'b0, 8'h47, 64'h0},
    {1'b1, 1'b0, 8'h18, 64'h0000_0000_0000_00C3},
    {1'b0, 1'b0, 8'h18, 64'h0},
    {1'b0, 1'b1, 8'h1F, 64'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_size = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, mem_en, mem_we;
  logic [63:0] rsp_data, mem_wdata, mem_rdata;
  logic [AW-4:0] mem_addr;

  always #2.5 clk = ~clk;

  byte_word_adapter #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [63:0] mem [NW];
  logic [7:0]  shd [256];
  int nrd, nwr, nrsp;
  logic [AW-4:0] la [4];
  logic [63:0]   ld [4];
  int nchk = 0, nfail = 0;

  always @(posedge clk) begin
    if (rsp_valid) nrsp++;
    if (mem_en) begin
      if (nrd + nwr < 4) begin
        la[nrd + nwr] = mem_addr;
        ld[nrd + nwr] = mem_wdata;
      end
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        nwr++;
      end else begin
        mem_rdata <= mem[mem_addr];
        nrd++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] shd_word(input logic [7:0] a);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[8*k +: 8] = shd[8'(a + k)];
    return w;
  endfunction

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic run_op(input logic wr, input logic sz, input logic [7:0] a, input logic [63:0] wd);
    logic unal, got;
    int lat;
    logic [63:0] data, exp;
    unal = (a[2:0] != 3'd0);
    @(negedge clk);
    nrd = 0; nwr = 0; nrsp = 0;
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R8 busy window, R7 error pulse
    chk(req_ready == (wr && sz), "R8 ready after accept", 64'(req_ready), 64'(wr && sz));
    chk(rsp_err == (wr && sz && unal), "R7 error pulse", 64'(rsp_err), 64'(wr && sz && unal));
    got = 1'b0; lat = -1; data = '0;
    for (int n = 0; n < 6; n++) begin
      if (n > 0) @(negedge clk);
      if (rsp_valid && !got) begin got = 1'b1; lat = n; data = rsp_data; end
    end
    if (!wr) begin
      exp = sz ? shd_word(a) : {56'd0, shd[a]};
      chk(data == exp, sz ? (unal ? "R4 split read data" : "R3 word read data") : "R2 byte read data", data, exp);
      chk(lat == ((sz && unal) ? 2 : 1), "R3/R4 latency", 64'(lat), 64'((sz && unal) ? 2 : 1));
      chk(nrd == ((sz && unal) ? 2 : 1) && nwr == 0, "R4 fetch count", 64'(nrd), 64'((sz && unal) ? 2 : 1));
      chk(la[0] == a[7:3], "R1 first word index", 64'(la[0]), 64'(a[7:3]));
      if (sz && unal)
        chk(la[1] == 5'(a[7:3] + 1), "R4 second word index", 64'(la[1]), 64'(5'(a[7:3] + 1)));
      chk(nrsp == 1, "R10 one response", 64'(nrsp), 64'd1);
    end else if (!sz) begin
      shd[a] = wd[7:0];
      exp = shd_word({a[7:3], 3'b000});
      chk(nrd == 1 && nwr == 1, "R5 read then write", 64'(nrd * 16 + nwr), 64'h11);
      chk(la[1] == a[7:3] && ld[1] == exp, "R5 written word", ld[1], exp);
      chk(nrsp == 0, "R10 no response on write", 64'(nrsp), 64'd0);
    end else if (!unal) begin
      for (int k = 0; k < 8; k++) shd[8'(a + k)] = wd[8*k +: 8];
      chk(nrd == 0 && nwr == 1 && la[0] == a[7:3] && ld[0] == wd, "R6 direct word write", ld[0], wd);
    end else begin
      chk(nrd == 0 && nwr == 0, "R7 no memory access", 64'(nrd + nwr), 64'd0);
    end
  endtask

  initial begin
    #(5.0 * 20000);
    nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) shd[i] = 8'((i * 7 + 3) & 255);
    for (int w = 0; w < NW; w++) mem[w] = shd_word(8'(w * 8));
    mem_rdata = '0;
    nrd = 0; nwr = 0; nrsp = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(req_ready && !mem_en && !rsp_valid && !rsp_err, "R9 reset state",
        {60'd0, req_ready, mem_en, rsp_valid, rsp_err}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_en && !rsp_valid, "R9 after reset", {61'd0, req_ready, mem_en, rsp_valid}, 64'h4);

    for (int i = 0; i < NV; i++) begin
      logic [73:0] v;
      v = VEC[i];
      run_op(v[73], v[72], v[71:64], v[63:0]);
    end

    // R9 reset in the middle of a split read drops it
    @(negedge clk);
    nrsp = 0;
    req_valid = 1'b1; req_write = 1'b0; req_size = 1'b1; req_addr = 8'h2B;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_en && !rsp_valid, "R9 mid-op reset idle", {61'd0, req_ready, mem_en, rsp_valid}, 64'h4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(nrsp == 0, "R9 abandoned op no response", 64'(nrsp), 64'd0);

    // R7 memory word unchanged after refused write, seen through port
    run_op(1'b1, 1'b1, 8'h31, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op(1'b0, 1'b1, 8'h30, 64'h0);
    run_op(1'b0, 1'b1, 8'h38, 64'h0);

    report();
  end
endmodule